// File: doc/BRIEF.md
# DSP Operand and Result Formatter

This block sits between the register file of a DSP datapath and its 40-bit arithmetic unit. Each source operand leaves the block 40 bits wide. How the block widens it depends on the class of the operation (fixed-point, integer or logical) and on the kind of register the operand came from. The two accumulators are 40 bits wide; their top eight bits are guard bits. The other six registers are 32 bits wide.

On the write-back side the block takes the 40-bit result and shapes it for the destination register. It produces the write data, a per-bit write mask and a one-hot write enable. The block is purely combinational. Arithmetic, instruction decode and register storage are done elsewhere.

Register codes, 3 bits: 0 first accumulator, 1 second accumulator, 2 and 3 multiplier registers, 4 and 5 X data registers, 6 and 7 Y data registers. Operation class, 2 bits: 00 fixed-point, 01 integer, 10 logical, 11 reserved.

Top module: `dsp_operand_fmt`

## Requirements
- R1: In fixed-point class, a source with code 0 or 1 (accumulator) is passed through on all 40 bits.
- R2: In fixed-point class, a source with code 2 to 7 supplies its raw bits 31:0 unchanged. Bits 39:32 of the operand are copies of raw bit 31, and raw bits 39:32 have no effect on the operand.
- R3: In integer class (01), each operand equals its fixed-point value with bits 15:0 forced to zero.
- R4: In logical class (10), each operand carries raw bits 31:16 in bits 31:16, and every other operand bit is zero, for accumulators and other registers alike.
- R5: In fixed-point class, an accumulator destination receives write data equal to the full 40-bit result.
- R6: For a destination with code 2 to 7, write data bits 39:32 are zero in every class, and write mask bits 39:32 are zero while mask bits 31:0 are one. For an accumulator destination, all 40 mask bits are one.
- R7: In integer class, write data equals the fixed-point write data with bits 15:0 cleared.
- R8: In logical class, write data holds result bits 31:16 in bits 31:16 and zero everywhere else, so an accumulator's guard bits and lower word are written as zero.
- R9: Class code 11 gives exactly the same outputs as class code 00.
- R10: The write enable has exactly one bit set, at the index equal to the destination code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_sel | input | 3 | Register code of the first source |
| src_a_raw | input | 40 | Raw content of the first source; bits 39:32 only meaningful for accumulators |
| src_b_sel | input | 3 | Register code of the second source |
| src_b_raw | input | 40 | Raw content of the second source |
| op_class | input | 2 | Operation class |
| dst_sel | input | 3 | Register code of the destination |
| result | input | 40 | Result from the arithmetic unit |
| opnd_a | output | 40 | Shaped first operand |
| opnd_b | output | 40 | Shaped second operand |
| wr_data | output | 40 | Shaped write-back data |
| wr_mask | output | 40 | Per-bit write mask for the destination |
| wr_en | output | 8 | One-hot register write enable |

## Verification
Every register code is paired with every class code, including the reserved one. The raw values used are chosen to tell the rules apart:
- A negative body with garbage guard bits separates sign extension from guard pass-through (R1, R2).
- A positive body with set guard bits shows whether guard bits leak into a 32-bit register's operand.
- A pattern with only low-word bits set exposes the integer and logical clearing (R3, R4).

Random operands and results are then compared against a behavioural model on every clock. The two sources use different register kinds, so a swapped or shared shaping path shows up as a mismatch.

// File: rtl/dspfmt_pkg.sv
package dspfmt_pkg;

    localparam int ACC_W    = 40;
    localparam int REG_W    = 32;
    localparam int LO_W     = 16;
    localparam int SEL_W    = 3;
    localparam int NUM_REGS = 2 ** SEL_W;

    typedef enum logic [1:0] {
        CLS_FIXED = 2'b00,
        CLS_INT   = 2'b01,
        CLS_LOGIC = 2'b10,
        CLS_RSVD  = 2'b11
    } op_class_e;

    typedef enum logic [SEL_W-1:0] {
        RG_ACC0 = 3'd0,
        RG_ACC1 = 3'd1,
        RG_MUL0 = 3'd2,
        RG_MUL1 = 3'd3,
        RG_XD0  = 3'd4,
        RG_XD1  = 3'd5,
        RG_YD0  = 3'd6,
        RG_YD1  = 3'd7
    } reg_code_e;

    // Internal shaping mode derived from the operation class.
    typedef enum logic [1:0] {
        SHAPE_FULL  = 2'd0,
        SHAPE_INT   = 2'd1,
        SHAPE_LOGIC = 2'd2
    } shape_e;

    function automatic shape_e class_to_shape(input logic [1:0] cls);
        shape_e s;
        unique case (cls)
            CLS_INT:   s = SHAPE_INT;
            CLS_LOGIC: s = SHAPE_LOGIC;
            default:   s = SHAPE_FULL;   // fixed-point and reserved code
        endcase
        return s;
    endfunction

    function automatic logic is_acc(input logic [SEL_W-1:0] sel);
        return (sel == RG_ACC0) || (sel == RG_ACC1);
    endfunction

endpackage

// File: rtl/dspfmt_src_shape.sv
module dspfmt_src_shape
    import dspfmt_pkg::*;
#(
    parameter int P_ACC_W = ACC_W,
    parameter int P_REG_W = REG_W,
    parameter int P_LO_W  = LO_W
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [P_ACC_W-1:0] raw,
    input  shape_e             shape,
    output logic [P_ACC_W-1:0] opnd
);
    localparam int GUARD_W = P_ACC_W - P_REG_W;

    logic               acc;
    logic [GUARD_W-1:0] guard;
    logic [P_REG_W-1:0] body;

    always_comb begin
        acc   = is_acc(sel);
        body  = raw[P_REG_W-1:0];
        guard = acc ? raw[P_ACC_W-1:P_REG_W] : {GUARD_W{raw[P_REG_W-1]}};
        unique case (shape)
            SHAPE_FULL:  opnd = {guard, body};
            SHAPE_INT:   opnd = {guard, body[P_REG_W-1:P_LO_W], {P_LO_W{1'b0}}};
            SHAPE_LOGIC: opnd = {{GUARD_W{1'b0}}, body[P_REG_W-1:P_LO_W], {P_LO_W{1'b0}}};
            default:     opnd = '0;
        endcase
    end
endmodule

// File: rtl/dspfmt_dst_shape.sv
module dspfmt_dst_shape
    import dspfmt_pkg::*;
#(
    parameter int P_ACC_W = ACC_W,
    parameter int P_REG_W = REG_W,
    parameter int P_LO_W  = LO_W
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [P_ACC_W-1:0] result,
    input  shape_e             shape,
    output logic [P_ACC_W-1:0] wr_data,
    output logic [P_ACC_W-1:0] wr_mask
);
    localparam int GUARD_W = P_ACC_W - P_REG_W;

    logic               acc;
    logic [GUARD_W-1:0] guard_keep;

    always_comb begin
        acc        = is_acc(sel);
        guard_keep = acc ? result[P_ACC_W-1:P_REG_W] : '0;
        wr_mask    = acc ? '1 : {{GUARD_W{1'b0}}, {P_REG_W{1'b1}}};
        unique case (shape)
            SHAPE_FULL:  wr_data = {guard_keep, result[P_REG_W-1:0]};
            SHAPE_INT:   wr_data = {guard_keep, result[P_REG_W-1:P_LO_W], {P_LO_W{1'b0}}};
            SHAPE_LOGIC: wr_data = {{GUARD_W{1'b0}}, result[P_REG_W-1:P_LO_W], {P_LO_W{1'b0}}};
            default:     wr_data = '0;
        endcase
    end
endmodule

// File: rtl/dspfmt_dst_onehot.sv
module dspfmt_dst_onehot
    import dspfmt_pkg::*;
#(
    parameter int P_NUM = NUM_REGS
) (
    input  logic [SEL_W-1:0] sel,
    output logic [P_NUM-1:0] en
);
    for (genvar i = 0; i < P_NUM; i++) begin : g_dec
        assign en[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/dsp_operand_fmt.sv
module dsp_operand_fmt
    import dspfmt_pkg::*;
(
    input  logic [SEL_W-1:0]    src_a_sel,
    input  logic [ACC_W-1:0]    src_a_raw,
    input  logic [SEL_W-1:0]    src_b_sel,
    input  logic [ACC_W-1:0]    src_b_raw,
    input  logic [1:0]          op_class,
    input  logic [SEL_W-1:0]    dst_sel,
    input  logic [ACC_W-1:0]    result,
    output logic [ACC_W-1:0]    opnd_a,
    output logic [ACC_W-1:0]    opnd_b,
    output logic [ACC_W-1:0]    wr_data,
    output logic [ACC_W-1:0]    wr_mask,
    output logic [NUM_REGS-1:0] wr_en
);
    localparam int NUM_SRC = 2;

    shape_e           shape;
    logic [SEL_W-1:0] sel_v [NUM_SRC];
    logic [ACC_W-1:0] raw_v [NUM_SRC];
    logic [ACC_W-1:0] opn_v [NUM_SRC];

    assign shape    = class_to_shape(op_class);
    assign sel_v[0] = src_a_sel;
    assign sel_v[1] = src_b_sel;
    assign raw_v[0] = src_a_raw;
    assign raw_v[1] = src_b_raw;
    assign opnd_a   = opn_v[0];
    assign opnd_b   = opn_v[1];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        dspfmt_src_shape u_src (
            .sel   (sel_v[s]),
            .raw   (raw_v[s]),
            .shape (shape),
            .opnd  (opn_v[s])
        );
    end

    dspfmt_dst_shape u_dst (
        .sel     (dst_sel),
        .result  (result),
        .shape   (shape),
        .wr_data (wr_data),
        .wr_mask (wr_mask)
    );

    dspfmt_dst_onehot u_en (
        .sel (dst_sel),
        .en  (wr_en)
    );
endmodule

// File: rtl/dsp_operand_fmt_chk.sv
module dsp_operand_fmt_chk
    import dspfmt_pkg::*;
(
    input logic [SEL_W-1:0]    src_a_sel,
    input logic [ACC_W-1:0]    src_a_raw,
    input logic [1:0]          op_class,
    input logic [SEL_W-1:0]    dst_sel,
    input logic [ACC_W-1:0]    opnd_a,
    input logic [ACC_W-1:0]    opnd_b,
    input logic [ACC_W-1:0]    wr_data,
    input logic [ACC_W-1:0]    wr_mask,
    input logic [NUM_REGS-1:0] wr_en
);
    logic fx, a_acc, d_acc;
    assign fx    = (op_class == 2'b00) || (op_class == 2'b11);
    assign a_acc = (src_a_sel < 3'd2);
    assign d_acc = (dst_sel < 3'd2);

    always_comb begin
        AST_ACC_SRC_PASS:  assert (!(fx && a_acc) || opnd_a == src_a_raw); // R1
        AST_SRC_SIGN_EXT:  assert (!(fx && !a_acc) || opnd_a[39:32] == {8{src_a_raw[31]}}); // R2
        AST_INT_LOW_CLEAR: assert (!(op_class == 2'b01) || (opnd_a[15:0] == 16'h0 && opnd_b[15:0] == 16'h0)); // R3
        AST_LOGIC_SRC:     assert (!(op_class == 2'b10) || (opnd_a[39:32] == 8'h0 && opnd_a[15:0] == 16'h0)); // R4
        AST_DST_MASK:      assert (d_acc ? (wr_mask == '1) : (wr_mask[39:32] == 8'h0 && wr_data[39:32] == 8'h0)); // R6
        AST_INT_WB_LOW:    assert (!(op_class == 2'b01) || wr_data[15:0] == 16'h0); // R7
        AST_EN_ONEHOT:     assert ($countones(wr_en) == 1 && wr_en[dst_sel]); // R10
    end
endmodule

bind dsp_operand_fmt dsp_operand_fmt_chk u_chk (
    .src_a_sel (src_a_sel),
    .src_a_raw (src_a_raw),
    .op_class  (op_class),
    .dst_sel   (dst_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .wr_en     (wr_en)
);

// File: tb/dsp_operand_fmt_tb.sv
module dsp_operand_fmt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [2:0]  sa;
        logic [39:0] ra;
        logic [2:0]  sb;
        logic [39:0] rb;
        logic [1:0]  cls;
        logic [2:0]  ds;
        logic [39:0] res;
    } vec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_a_sel = '0, src_b_sel = '0, dst_sel = '0;
    logic [39:0] src_a_raw = '0, src_b_raw = '0, result = '0;
    logic [1:0]  op_class = '0;
    logic [39:0] opnd_a, opnd_b, wr_data, wr_mask;
    logic [7:0]  wr_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    vec_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_operand_fmt u_dut (
        .src_a_sel (src_a_sel), .src_a_raw (src_a_raw),
        .src_b_sel (src_b_sel), .src_b_raw (src_b_raw),
        .op_class  (op_class),  .dst_sel   (dst_sel),
        .result    (result),
        .opnd_a    (opnd_a),    .opnd_b    (opnd_b),
        .wr_data   (wr_data),   .wr_mask   (wr_mask),
        .wr_en     (wr_en)
    );

    // Behavioural reference
    function automatic logic [39:0] m_src(logic [2:0] sel, logic [39:0] raw, logic [1:0] cls);
        logic signed [39:0] v;
        if (sel <= 3'd1) v = raw;
        else             v = 40'($signed(raw[31:0]));
        if (cls == 2'd1) return v & 40'hFF_FFFF_0000;
        if (cls == 2'd2) return v & 40'h00_FFFF_0000;
        return v;
    endfunction

    function automatic logic [39:0] m_data(logic [2:0] sel, logic [39:0] res, logic [1:0] cls);
        logic [39:0] v;
        v = (sel <= 3'd1) ? res : (res & 40'h00_FFFF_FFFF);
        if (cls == 2'd1) return v & 40'hFF_FFFF_0000;
        if (cls == 2'd2) return v & 40'h00_FFFF_0000;
        return v;
    endfunction

    function automatic string src_tag(logic [2:0] sel, logic [1:0] cls);
        if (cls == 2'd1) return "R3";
        if (cls == 2'd2) return "R4";
        if (cls == 2'd3) return "R9";
        return (sel <= 3'd1) ? "R1" : "R2";
    endfunction

    function automatic string dst_tag(logic [2:0] sel, logic [1:0] cls);
        if (cls == 2'd1) return "R7";
        if (cls == 2'd2) return "R8";
        if (cls == 2'd3) return "R9";
        return (sel <= 3'd1) ? "R5" : "R6";
    endfunction

    task automatic cmp(string tag, string what, logic [39:0] act, logic [39:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        cmp(src_tag(src_a_sel, op_class), "opnd_a", opnd_a, m_src(src_a_sel, src_a_raw, op_class));
        cmp(src_tag(src_b_sel, op_class), "opnd_b", opnd_b, m_src(src_b_sel, src_b_raw, op_class));
        cmp(dst_tag(dst_sel, op_class), "wr_data", wr_data, m_data(dst_sel, result, op_class));
        cmp("R6", "wr_mask", wr_mask, (dst_sel <= 3'd1) ? 40'hFF_FFFF_FFFF : 40'h00_FFFF_FFFF);
        cmp("R10", "wr_en", 40'(wr_en), 40'(8'd1 << dst_sel));
    endtask

    function automatic logic [39:0] r40();
        return {8'($urandom), 32'($urandom)};
    endfunction

    initial begin
        logic [39:0] pats [4];
        pats[0] = 40'h5A_8000_8001;   // negative body, garbage guard
        pats[1] = 40'hC3_7FFF_FFFF;   // positive body, guard set
        pats[2] = 40'h00_0000_FFFF;   // low word only
        pats[3] = 40'hFF_FFFF_0000;   // high parts only
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 8; s++)
                for (int p = 0; p < 4; p++)
                    q.push_back('{sa: 3'(s), ra: pats[p], sb: 3'(7 - s), rb: pats[3 - p],
                                  cls: 2'(c), ds: 3'(s), res: pats[p] ^ 40'hA5_0F0F_F0F0});
        for (int i = 0; i < 400; i++)
            q.push_back('{sa: 3'($urandom), ra: r40(), sb: 3'($urandom), rb: r40(),
                          cls: 2'($urandom), ds: 3'($urandom), res: r40()});

        // reset state: all-zero inputs give zero operands and enable for code 0
        repeat (2) @(posedge clk);
        @(negedge clk);
        cmp("R1", "reset opnd_a", opnd_a, 40'h0);
        cmp("R5", "reset wr_data", wr_data, 40'h0);
        cmp("R10", "reset wr_en", 40'(wr_en), 40'h1);
        rst_n = 1'b1;

        while (q.size() > 0) begin
            vec_t v;
            v = q.pop_front();
            @(posedge clk);
            #1;
            src_a_sel = v.sa; src_a_raw = v.ra;
            src_b_sel = v.sb; src_b_raw = v.rb;
            op_class  = v.cls; dst_sel  = v.ds; result = v.res;
            @(negedge clk);
            check_all();
        end

        // R2: guard bits of a 32-bit register's raw value have no effect
        @(posedge clk); #1;
        op_class = 2'b00; src_a_sel = 3'd4; src_a_raw = 40'hFF_1234_5678;
        @(negedge clk);
        cmp("R2", "guard ignored", opnd_a, 40'h00_1234_5678);
        // R9: reserved code equals fixed-point
        @(posedge clk); #1;
        op_class = 2'b11; src_a_sel = 3'd0; src_a_raw = 40'h81_8765_4321;
        dst_sel = 3'd1; result = 40'h7E_0000_FFFF;
        @(negedge clk);
        cmp("R9", "reserved opnd_a", opnd_a, 40'h81_8765_4321);
        cmp("R9", "reserved wr_data", wr_data, 40'h7E_0000_FFFF);
        // R8: logical write to accumulator clears guard and low word
        @(posedge clk); #1;
        op_class = 2'b10;
        @(negedge clk);
        cmp("R8", "logic acc wb", wr_data, 40'h00_0000_0000);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule